// File: doc/BRIEF.md
# Block cipher register front-end

This block is the register and control layer that sits between a 32-bit word-addressed register bus and a 128-bit block cipher core. Software, or two DMA channels, load a key bank and an initial vector. They pick a direction, key size and chaining mode in a control register, then push each 16-byte block through a fixed four-word data window. The front-end assembles the block and launches the core with a one-cycle start pulse. When the core reports completion, the front-end captures the result and hands it back through the same window.

In chained (CBC) mode, the XOR with the vector is applied around the core. The vector register is then refreshed after every block, so a long stream can run as a series of bursts with no software rewrite. A configuration register holds the per-direction DMA enables, a global start bit and a self-clearing soft reset. A status bit reports when the soft reset has finished clearing the internal state.

Top module: `blkc_front`

## Requirements
- R1: After hardware reset, control (0x30) reads 0x00000002, meaning input ready is 1 and output ready is 0. The configuration register (0x48) reads 0 and the status register (0x4C) reads 1.
- R2: Key word i (0..7) is written and read at byte offset 0x1C − 4·(i XOR 1) and drives core_key_o bits 32i+31..32i. Vector word j (0..3) sits at offset 0x20 + 4j. Word 0 of a 128-bit value occupies bits 31..0.
- R3: In the control register, bit 0 is output ready and bit 1 is input ready; both are read-only. The writable bits are:
  - bit 2: encrypt
  - bits 4:3: key size, written as (key bytes / 8) − 1
  - bit 5: CBC
  - bit 6: counter mode
  - bit 7: counter width

  core_encrypt_o follows bit 2 and core_key_size_o follows bits 4:3.
- R4: Data words 0..3 are written at 0x34, 0x38, 0x3C and 0x40. A write to 0x40 while input ready is 1 clears input ready and produces a one-cycle core_start_o in the next cycle, with the block on core_block_o. Data writes while input ready is 0 are ignored.
- R5: core_done_i while a block is in flight sets output ready. The result words are then read at 0x34..0x40. Reading 0x40 while output ready is 1 clears output ready and sets input ready.
- R6: The result handling depends on the mode:
  - Non-chained: the output is the core result unchanged.
  - CBC encrypt: the block sent to the core is data XOR vector, and the vector becomes the result.
  - CBC decrypt: the output is result XOR vector, and the vector becomes the input block.
- R7: dma_in_req_o is 1 exactly when start (0x48 bit 5), input DMA enable (bit 2) and input ready are all 1. dma_out_req_o is 1 exactly when start, output DMA enable (bit 3) and output ready are all 1.
- R8: The revision register at 0x44 returns REV_MAJOR in bits 7:4 and REV_MINOR in bits 3:0.
- R9: Configuration bits 0, 2, 3, 5 and 6 read back as written and the other bits read 0. Writing bit 1 starts a soft reset; bit 1 reads 1 in the following cycle only.
- R10: A soft reset returns key, vector, control, configuration and data state to their reset values. Status bit 0 then reads 0 for exactly RST_CYCLES cycles, and all writes in that window are ignored.
- R11: When a soft reset write and core_done_i fall in the same cycle, the reset wins: output ready stays 0 and input ready reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address; accesses with nonzero bits 1:0 are ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe, else 0 |
| dma_in_req_o | output | 1 | Request for a four-word input burst |
| dma_out_req_o | output | 1 | Request for a four-word output burst |
| core_start_o | output | 1 | One-cycle launch of the cipher core |
| core_encrypt_o | output | 1 | Direction to the core, 1 = encrypt |
| core_key_size_o | output | 2 | Key size code to the core |
| core_key_o | output | 256 | Key bank, word i at bits 32i+31..32i |
| core_block_o | output | 128 | Block presented to the core |
| core_done_i | input | 1 | Core completion pulse |
| core_result_i | input | 128 | Core result, valid with core_done_i |

## Verification
The delicate overlap is a soft reset write landing in the same cycle as the core's completion pulse. If the two collide, the result could be half-captured, or output ready could be set on top of cleared state. The bench launches a block into a fixed-latency stub core and counts cycles so that the configuration write reaches the register in the exact cycle the stub raises its done pulse, and it confirms that alignment by observing the done pulse. It then judges the outcome at the ports: control must read input ready 1 and output ready 0, both during and after the reset window.

// File: rtl/blkc_pkg.sv
package blkc_pkg;
  localparam int unsigned KEY_WORDS = 8;
  localparam int unsigned BLK_WORDS = 4;
  localparam int unsigned KEY_BITS  = 32 * KEY_WORDS;
  localparam int unsigned BLK_BITS  = 32 * BLK_WORDS;

  // word indices (byte offset / 4); key slots occupy 0..KEY_WORDS-1
  localparam logic [5:0] W_IV0  = 6'(KEY_WORDS);
  localparam logic [5:0] W_CTRL = 6'd12;
  localparam logic [5:0] W_DAT0 = 6'd13;
  localparam logic [5:0] W_DATL = W_DAT0 + 6'(BLK_WORDS - 1);
  localparam logic [5:0] W_REV  = 6'd17;
  localparam logic [5:0] W_CFG  = 6'd18;
  localparam logic [5:0] W_STAT = 6'd19;

  localparam int unsigned CFG_SRST  = 1;
  localparam int unsigned CFG_DIN   = 2;
  localparam int unsigned CFG_DOUT  = 3;
  localparam int unsigned CFG_START = 5;
  localparam logic [6:0]  CFG_RW    = 7'b110_1101;

  typedef struct packed {
    logic       ctr_wide;
    logic       ctr;
    logic       cbc;
    logic [1:0] ksize;
    logic       enc;
  } mode_t;
endpackage

// File: rtl/blkc_keyiv.sv
module blkc_keyiv import blkc_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                wr_i,
  input  logic [5:0]          widx_i,
  input  logic [31:0]         wdata_i,
  input  logic                chain_i,
  input  logic [BLK_BITS-1:0] chain_val_i,
  output logic [KEY_BITS-1:0] key_o,
  output logic [BLK_BITS-1:0] iv_o,
  output logic [31:0]         rdata_o
);
  logic [31:0] key_q [KEY_WORDS];
  logic [31:0] iv_q  [BLK_WORDS];

  // R2: pairs swapped, descending from the top of the bank
  function automatic logic [5:0] key_slot(int i);
    return 6'(KEY_WORDS - 1 - (i ^ 1));
  endfunction

  for (genvar i = 0; i < KEY_WORDS; i++) begin : g_key
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                key_q[i] <= '0;
      else if (clr_i)                             key_q[i] <= '0;
      else if (wr_i && widx_i == key_slot(i))     key_q[i] <= wdata_i;
    end
    assign key_o[32*i +: 32] = key_q[i];
  end

  for (genvar j = 0; j < BLK_WORDS; j++) begin : g_iv
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                iv_q[j] <= '0;
      else if (clr_i)                             iv_q[j] <= '0;
      else if (chain_i)                           iv_q[j] <= chain_val_i[32*j +: 32];
      else if (wr_i && widx_i == W_IV0 + 6'(j))   iv_q[j] <= wdata_i;
    end
    assign iv_o[32*j +: 32] = iv_q[j];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < KEY_WORDS; i++)
      if (widx_i == key_slot(i)) rdata_o = key_q[i];
    for (int j = 0; j < BLK_WORDS; j++)
      if (widx_i == W_IV0 + 6'(j)) rdata_o = iv_q[j];
  end

  assert_chain_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_i && !clr_i |=> iv_o == $past(chain_val_i));
endmodule

// File: rtl/blkc_window.sv
module blkc_window import blkc_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [5:0]          widx_i,
  input  logic [31:0]         wdata_i,
  input  mode_t               mode_i,
  input  logic [BLK_BITS-1:0] iv_i,
  input  logic                core_done_i,
  input  logic [BLK_BITS-1:0] core_result_i,
  output logic                in_rdy_o,
  output logic                out_rdy_o,
  output logic                core_start_o,
  output logic [BLK_BITS-1:0] core_block_o,
  output logic                chain_o,
  output logic [BLK_BITS-1:0] chain_val_o,
  output logic [31:0]         rdata_o
);
  logic [BLK_BITS-1:0] in_q, out_q, out_d;
  logic                in_rdy_q, out_rdy_q, start_q;
  logic                hit, last_wr, last_rd, fin;
  logic [5:0]          off;
  logic [1:0]          sel;

  assign off     = widx_i - W_DAT0;
  assign sel     = off[1:0];
  assign hit     = (widx_i >= W_DAT0) && (widx_i <= W_DATL);
  assign last_wr = wr_i && in_rdy_q && widx_i == W_DATL;
  assign last_rd = rd_i && out_rdy_q && widx_i == W_DATL;
  // R11: soft reset suppresses a coincident completion
  assign fin     = core_done_i && !in_rdy_q && !out_rdy_q && !clr_i;

  // R6: XOR around the core for chained mode
  assign core_block_o = (mode_i.cbc && mode_i.enc) ? (in_q ^ iv_i) : in_q;
  assign out_d        = (mode_i.cbc && !mode_i.enc) ? (core_result_i ^ iv_i) : core_result_i;
  assign chain_o      = fin && mode_i.cbc;
  assign chain_val_o  = mode_i.enc ? core_result_i : in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q <= '0; out_q <= '0; in_rdy_q <= 1'b1; out_rdy_q <= 1'b0; start_q <= 1'b0;
    end else if (clr_i) begin
      in_q <= '0; out_q <= '0; in_rdy_q <= 1'b1; out_rdy_q <= 1'b0; start_q <= 1'b0;
    end else begin
      start_q <= last_wr;
      if (wr_i && in_rdy_q && hit) in_q[32*sel +: 32] <= wdata_i;
      if (last_wr) in_rdy_q <= 1'b0;
      if (fin) begin
        out_q     <= out_d;
        out_rdy_q <= 1'b1;
      end
      if (last_rd) begin
        out_rdy_q <= 1'b0;
        in_rdy_q  <= 1'b1;
      end
    end
  end

  assign in_rdy_o     = in_rdy_q;
  assign out_rdy_o    = out_rdy_q;
  assign core_start_o = start_q;
  assign rdata_o      = hit ? out_q[32*sel +: 32] : '0;

  assert_rdy_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_rdy_q && out_rdy_q));
  assert_start_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |=> !core_start_o);
  assert_start_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |-> $past(wr_i && widx_i == W_DATL) && !in_rdy_q);
  assert_out_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_rdy_q) |-> $past(core_done_i));
endmodule

// File: rtl/blkc_sysctl.sv
module blkc_sysctl import blkc_pkg::*; #(
  parameter int unsigned RST_CYCLES = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [5:0]  widx_i,
  input  logic [6:0]  wdata_i,
  input  logic        in_rdy_i,
  input  logic        out_rdy_i,
  output logic        done_o,
  output logic        clr_o,
  output logic        dma_in_req_o,
  output logic        dma_out_req_o,
  output logic [31:0] rdata_o
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);

  logic [6:0]    cfg_q;
  logic [CW-1:0] cnt_q;
  logic          cfg_wr;

  assign done_o = (cnt_q == '0);
  assign cfg_wr = wr_i && widx_i == W_CFG;
  assign clr_o  = cfg_wr && wdata_i[CFG_SRST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else if (clr_o) begin
      cfg_q <= 7'(1 << CFG_SRST);
      cnt_q <= CW'(RST_CYCLES);
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (cfg_q[CFG_SRST]) cfg_q[CFG_SRST] <= 1'b0;
      else if (cfg_wr)     cfg_q <= wdata_i & CFG_RW;
    end
  end

  // R7
  assign dma_in_req_o  = cfg_q[CFG_START] && cfg_q[CFG_DIN]  && in_rdy_i;
  assign dma_out_req_o = cfg_q[CFG_START] && cfg_q[CFG_DOUT] && out_rdy_i;

  assign rdata_o = ((widx_i == W_CFG)  ? {25'b0, cfg_q}  : 32'b0) |
                   ((widx_i == W_STAT) ? {31'b0, done_o} : 32'b0);

  assert_srst_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q[CFG_SRST] |=> !cfg_q[CFG_SRST]);
  assert_quiet_in_reset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !dma_in_req_o && !dma_out_req_o);
  assert_done_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> $past(clr_o));
endmodule

// File: rtl/blkc_front.sv
module blkc_front import blkc_pkg::*; #(
  parameter int unsigned RST_CYCLES = 8,
  parameter logic [3:0]  REV_MAJOR  = 4'd3,
  parameter logic [3:0]  REV_MINOR  = 4'd1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [7:0]          bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  output logic                dma_in_req_o,
  output logic                dma_out_req_o,
  output logic                core_start_o,
  output logic                core_encrypt_o,
  output logic [1:0]          core_key_size_o,
  output logic [KEY_BITS-1:0] core_key_o,
  output logic [BLK_BITS-1:0] core_block_o,
  input  logic                core_done_i,
  input  logic [BLK_BITS-1:0] core_result_i
);
  logic [5:0]          widx;
  logic                acc, wr_g, rd_g, done, clr;
  logic                in_rdy, out_rdy, chain;
  logic [BLK_BITS-1:0] iv, chain_val;
  logic [31:0]         kv_rd, win_rd, sys_rd, ctrl_rd;
  mode_t               mode_q;

  assign widx = bus_addr_i[7:2];
  assign acc  = bus_req_i && bus_addr_i[1:0] == 2'b00;
  assign wr_g = acc && bus_we_i && done;   // R10: writes locked while clearing
  assign rd_g = acc && !bus_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        mode_q <= '0;
    else if (clr)                       mode_q <= '0;
    else if (wr_g && widx == W_CTRL)    mode_q <= mode_t'(bus_wdata_i[7:2]);
  end

  blkc_sysctl #(.RST_CYCLES(RST_CYCLES)) u_sys (
    .clk_i, .rst_ni, .wr_i(wr_g), .widx_i(widx), .wdata_i(bus_wdata_i[6:0]),
    .in_rdy_i(in_rdy), .out_rdy_i(out_rdy), .done_o(done), .clr_o(clr),
    .dma_in_req_o, .dma_out_req_o, .rdata_o(sys_rd)
  );

  blkc_keyiv u_kv (
    .clk_i, .rst_ni, .clr_i(clr), .wr_i(wr_g), .widx_i(widx), .wdata_i(bus_wdata_i),
    .chain_i(chain), .chain_val_i(chain_val), .key_o(core_key_o), .iv_o(iv),
    .rdata_o(kv_rd)
  );

  blkc_window u_win (
    .clk_i, .rst_ni, .clr_i(clr), .wr_i(wr_g), .rd_i(rd_g), .widx_i(widx),
    .wdata_i(bus_wdata_i), .mode_i(mode_q), .iv_i(iv), .core_done_i,
    .core_result_i, .in_rdy_o(in_rdy), .out_rdy_o(out_rdy), .core_start_o,
    .core_block_o, .chain_o(chain), .chain_val_o(chain_val), .rdata_o(win_rd)
  );

  assign ctrl_rd         = {24'b0, mode_q, in_rdy, out_rdy};
  assign core_encrypt_o  = mode_q.enc;
  assign core_key_size_o = mode_q.ksize;

  assign bus_rdata_o = !rd_g ? 32'b0 :
                       (kv_rd | win_rd | sys_rd |
                        ((widx == W_CTRL) ? ctrl_rd : 32'b0) |
                        ((widx == W_REV)  ? {24'b0, REV_MAJOR, REV_MINOR} : 32'b0));
endmodule

// File: tb/sim_blkc_front.sv
`timescale 1ns/1ps
module sim_blkc_front;
  localparam int RSTC = 8;
  localparam int LAT  = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         dma_in, dma_out, start, enc;
  logic [1:0]   ksz;
  logic [255:0] key;
  logic [127:0] blk;
  logic         done = 1'b0;
  logic [127:0] res = '0;

  always #2 clk = ~clk;

  blkc_front #(.RST_CYCLES(RSTC), .REV_MAJOR(4'd3), .REV_MINOR(4'd1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .dma_in_req_o(dma_in), .dma_out_req_o(dma_out),
    .core_start_o(start), .core_encrypt_o(enc), .core_key_size_o(ksz), .core_key_o(key),
    .core_block_o(blk), .core_done_i(done), .core_result_i(res)
  );

  // fixed-latency stub core: result = block XOR low key half
  int           lat = 0;
  logic [127:0] held = '0;
  always @(posedge clk) begin
    done <= 1'b0;
    if (start) begin
      lat  <= LAT;
      held <= blk ^ key[127:0];
    end else if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin done <= 1'b1; res <= held; end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0]  mkey [8];
  logic [127:0] miv;
  logic [31:0]  v;

  task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a; #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  function automatic logic [7:0] kaddr(input int i);
    return 8'(8'h1C - 4 * (i ^ 1));
  endfunction

  function automatic logic [127:0] klow();
    return {mkey[3], mkey[2], mkey[1], mkey[0]};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // expected core input and output for a block under a mode
  function automatic logic [127:0] exp_in(input logic [127:0] p, input bit cbc, input bit e);
    return (cbc && e) ? (p ^ miv) : p;
  endfunction
  function automatic logic [127:0] exp_out(input logic [127:0] p, input bit cbc, input bit e);
    logic [127:0] r = exp_in(p, cbc, e) ^ klow();
    return (cbc && !e) ? (r ^ miv) : r;
  endfunction

  task automatic wait_out();
    logic [31:0] c;
    for (int t = 0; t < 40; t++) begin
      rd(8'h30, c);
      if (c[0]) break;
    end
    chk("R5 output ready set", {127'b0, c[0]}, 128'd1);
  endtask

  task automatic send(input logic [127:0] p, input bit cbc, input bit e, input bit poke,
                      output logic [127:0] r);
    logic [31:0] c;
    for (int j = 0; j < 4; j++) wr(8'(8'h34 + 4 * j), p[32*j +: 32]);
    chk("R4 start pulse", {127'b0, start}, 128'd1);
    chk("R4/R6 block to core", blk, exp_in(p, cbc, e));
    if (poke) wr(8'h34, 32'hA5A5_5A5A);   // ignored: input not ready
    wait_out();
    for (int j = 0; j < 4; j++) begin
      rd(8'(8'h34 + 4 * j), c);
      r[32*j +: 32] = c;
    end
    rd(8'h30, c);
    chk("R5 ready flags after final read", {126'b0, c[1:0]}, 128'd2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin : main
    logic [127:0] p, r, e128;
    v = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1, R8
    rd(8'h30, v); chk("R1 control default", {96'b0, v}, 128'h2);
    rd(8'h48, v); chk("R1 config default", {96'b0, v}, 128'h0);
    rd(8'h4C, v); chk("R1 status default", {96'b0, v}, 128'h1);
    rd(8'h44, v); chk("R8 revision", {96'b0, v}, 128'h31);

    // R2 key bank placement and vector bank
    for (int i = 0; i < 8; i++) begin
      mkey[i] = $urandom;
      wr(kaddr(i), mkey[i]);
    end
    for (int i = 0; i < 8; i++) begin
      chk("R2 key word on core port", {96'b0, key[32*i +: 32]}, {96'b0, mkey[i]});
      rd(kaddr(i), v); chk("R2 key readback", {96'b0, v}, {96'b0, mkey[i]});
    end
    miv = rnd128();
    for (int j = 0; j < 4; j++) wr(8'(8'h20 + 4 * j), miv[32*j +: 32]);
    for (int j = 0; j < 4; j++) begin
      rd(8'(8'h20 + 4 * j), v); chk("R2 vector readback", {96'b0, v}, {96'b0, miv[32*j +: 32]});
    end

    // R3 control fields
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, v); chk("R3 control readback", {96'b0, v}, 128'hFE);
    chk("R3 encrypt to core", {127'b0, enc}, 128'd1);
    chk("R3 key size to core", {126'b0, ksz}, 128'd3);
    wr(8'h30, 32'h0C);   // non-chained encrypt, 128-bit key
    rd(8'h30, v); chk("R3 control readback", {96'b0, v}, 128'h0E);
    chk("R3 key size 128-bit", {126'b0, ksz}, 128'd1);

    // R4 R5 R6 non-chained
    for (int k = 0; k < 4; k++) begin
      p = rnd128(); e128 = exp_out(p, 0, 1);
      send(p, 0, 1, 0, r);
      chk("R6 non-chained output", r, e128);
    end

    // R6 chained encrypt
    wr(8'h30, 32'h2C);
    for (int k = 0; k < 3; k++) begin
      p = rnd128(); e128 = exp_out(p, 1, 1);
      send(p, 1, 1, 0, r);
      chk("R6 cbc encrypt output", r, e128);
      miv = e128;
      for (int j = 0; j < 4; j++) begin
        rd(8'(8'h20 + 4 * j), v); chk("R6 vector = ciphertext", {96'b0, v}, {96'b0, miv[32*j +: 32]});
      end
    end

    // R6 chained decrypt, R4 write while busy ignored
    wr(8'h30, 32'h28);
    for (int k = 0; k < 3; k++) begin
      p = rnd128(); e128 = exp_out(p, 1, 0);
      send(p, 1, 0, k == 1, r);
      chk("R6 cbc decrypt output", r, e128);
      miv = p;
      for (int j = 0; j < 4; j++) begin
        rd(8'(8'h20 + 4 * j), v); chk("R4/R6 vector = input block", {96'b0, v}, {96'b0, miv[32*j +: 32]});
      end
    end

    // R7 DMA request gating
    wr(8'h30, 32'h0C);
    wr(8'h48, 32'h0C);   // enables without start
    chk("R7 no input request without start", {127'b0, dma_in}, 128'd0);
    wr(8'h48, 32'h2C);
    chk("R7 input request", {127'b0, dma_in}, 128'd1);
    chk("R7 no output request", {127'b0, dma_out}, 128'd0);
    p = rnd128();
    for (int j = 0; j < 4; j++) wr(8'(8'h34 + 4 * j), p[32*j +: 32]);
    chk("R7 input request drops on launch", {127'b0, dma_in}, 128'd0);
    wait_out();
    chk("R7 output request", {127'b0, dma_out}, 128'd1);
    for (int j = 0; j < 4; j++) rd(8'(8'h34 + 4 * j), v);
    chk("R7 output request drops", {127'b0, dma_out}, 128'd0);
    chk("R7 input request returns", {127'b0, dma_in}, 128'd1);
    wr(8'h48, 32'h24);   // start + input only
    wr(8'h48, 32'h00);
    chk("R7 start cleared", {127'b0, dma_in}, 128'd0);

    // R9 configuration bits
    wr(8'h48, 32'hFFFF_FFFD);
    rd(8'h48, v); chk("R9 config writable bits", {96'b0, v}, 128'h6D);

    // R9 R10 soft reset
    wr(8'h48, 32'h2);
    req = 1; we = 0; addr = 8'h48; #1;
    chk("R9 soft reset bit visible", {96'b0, rdata}, 128'h2);
    @(negedge clk); #1;
    chk("R9 soft reset bit self-clears", {96'b0, rdata}, 128'h0);
    addr = 8'h4C;
    for (int k = 1; k <= RSTC; k++) begin
      #0;
      chk("R10 reset-done timing", {96'b0, rdata}, (k < RSTC) ? 128'h0 : 128'h1);
      @(negedge clk); #1;
    end
    req = 0;
    rd(8'h30, v); chk("R10 control cleared", {96'b0, v}, 128'h2);
    rd(kaddr(3), v); chk("R10 key cleared", {96'b0, v}, 128'h0);
    chk("R10 key port cleared", key[127:0], 128'h0);
    rd(8'h2C, v); chk("R10 vector cleared", {96'b0, v}, 128'h0);
    rd(8'h34, v); chk("R10 data cleared", {96'b0, v}, 128'h0);

    // R10 writes ignored while clearing
    wr(8'h48, 32'h2);
    wr(kaddr(0), 32'hDEAD_BEEF);
    repeat (RSTC) @(negedge clk);
    rd(kaddr(0), v); chk("R10 write during clear ignored", {96'b0, v}, 128'h0);

    // R11 soft reset coincides with completion
    for (int i = 0; i < 4; i++) begin mkey[i] = $urandom; wr(kaddr(i), mkey[i]); end
    wr(8'h30, 32'h0C);
    p = rnd128();
    for (int j = 0; j < 4; j++) wr(8'(8'h34 + 4 * j), p[32*j +: 32]);
    repeat (LAT) @(negedge clk);
    @(negedge clk);
    chk("R11 done pulse aligned", {127'b0, done}, 128'd1);
    req = 1; we = 1; addr = 8'h48; wdata = 32'h2;
    @(negedge clk); req = 0; we = 0;
    rd(8'h30, v); chk("R11 reset wins over completion", {96'b0, v}, 128'h2);
    repeat (RSTC) @(negedge clk);
    rd(8'h30, v); chk("R11 no late output ready", {96'b0, v}, 128'h2);

    report();
  end
endmodule